// File: doc/BRIEF.md
# Wavefront Lane Permutation Unit

This block moves 32-bit words between the 64 lanes of a SIMD wavefront. On each accepted input it takes the full set of lane values, a mode code, an 8-bit control byte, a fill-select flag and a vector of per-lane prior values. It then writes, one cycle later, a new 64-lane vector in which every lane holds the word it fetched from some other lane. The lane groups are fixed. A quad is 4 consecutive lanes, a half-row is 8, and a row is 16, so the wavefront holds four rows.

Some lanes have no valid source. A shift may push a lane's source past the edge of its row or past the end of the wavefront. For such a lane, the fill-select flag decides between a zero word and the lane's prior value. The two broadcast modes write only some rows; the other rows always keep their prior values. A row mode with a zero amount, and any unassigned mode code, is treated as a pass-through. In that case an error flag is raised alongside the result.

Top module: `lperm_top`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_err` and every bit of `out_data` are 0 until the first accepted input.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `out_data` and `out_err` change only on such a cycle and hold their values otherwise.
- R3: Mode 0 (quad crossbar): lane 4q+i takes source lane 4q+k. Here k is the 2-bit field `ctrl[2i+1:2i]`, so field 0 sits in the low bits.
- R4: Mode 1 (wave shift left) gives lane i the value of lane i+1, and lane 63 has no source. Mode 2 (wave shift right) gives lane i the value of lane i-1, and lane 0 has no source.
- R5: Mode 3 (wave rotate left) gives lane i the value of lane (i+1) mod 64. Mode 4 (wave rotate right) gives lane i the value of lane (i-1) mod 64.
- R6: Let n be `ctrl[3:0]`, let p be the lane's position within its row, and let b be the row's first lane. Mode 5 (row shift left) reads lane b+p+n. Mode 6 (row shift right) reads lane b+p-n. A source outside 0..15 within the row has no source.
- R7: Mode 7 (row rotate right) gives a lane at position p the value of lane b+((p-n) mod 16).
- R8: A lane with no source receives 0 when `bound_zero` is 1, and its `old_data` word when `bound_zero` is 0.
- R9: Mode 8 (row mirror) reads lane b+15-p. Mode 9 (half-row mirror) reads the lane at half-row position 7-h in the same half-row, where h is the lane's position within its half-row.
- R10: Mode 10 (broadcast-15): every lane of rows 1, 2 and 3 takes the value of the last lane of the row before it. Row 0 keeps `old_data` whatever `bound_zero` is.
- R11: Mode 11 (broadcast-31): every lane of rows 2 and 3 takes lane 31. Rows 0 and 1 keep `old_data` whatever `bound_zero` is.
- R12: Modes 5, 6 and 7 with n = 0, and mode codes 12 to 15, pass every lane through unchanged and set `out_err` with that result.
- R13: `out_err` is 0 with the result of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; the inputs are captured in this cycle |
| mode | input | 4 | Permutation mode code (0 to 11 legal) |
| ctrl | input | 8 | Quad selector fields, or the row amount in the low 4 bits |
| bound_zero | input | 1 | Fill for lanes with no source: 1 gives zero, 0 gives the prior value |
| src_data | input | 2048 | Lane values; lane i in bits 32i+31:32i |
| old_data | input | 2048 | Per-lane prior values, same layout |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 2048 | Permuted lane values, same layout |
| out_err | output | 1 | Illegal row amount or unassigned mode for this result |

## Verification
Every result, `out_data`, `out_valid` and `out_err` alike, is due at the first rising edge after the cycle that holds `in_valid`. Nothing else registers these signals on the way. The bench drives each input set on a falling edge and raises the strobe for exactly one cycle. It reads all three outputs at the next falling edge, half a cycle after the capturing edge. The hold scenario then changes the inputs with the strobe low and reads again one cycle later. A moved output in that read would show a capture without a strobe.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    localparam logic [3:0] MD_QUAD     = 4'd0;
    localparam logic [3:0] MD_WAVE_SHL = 4'd1;
    localparam logic [3:0] MD_WAVE_SHR = 4'd2;
    localparam logic [3:0] MD_WAVE_ROL = 4'd3;
    localparam logic [3:0] MD_WAVE_ROR = 4'd4;
    localparam logic [3:0] MD_ROW_SHL  = 4'd5;
    localparam logic [3:0] MD_ROW_SHR  = 4'd6;
    localparam logic [3:0] MD_ROW_ROR  = 4'd7;
    localparam logic [3:0] MD_ROW_MIR  = 4'd8;
    localparam logic [3:0] MD_HALF_MIR = 4'd9;
    localparam logic [3:0] MD_BC15     = 4'd10;
    localparam logic [3:0] MD_BC31     = 4'd11;

    // What a lane finally writes: the fetched word, a zero, or its prior value.
    typedef enum logic [1:0] {
        PK_SRC  = 2'd0,
        PK_ZERO = 2'd1,
        PK_OLD  = 2'd2
    } pick_e;

    // The row modes need a nonzero amount; codes past the broadcasts are unassigned.
    function automatic logic mode_illegal(input logic [3:0] mode, input logic amt_zero);
        logic bad;
        unique case (mode)
            MD_ROW_SHL, MD_ROW_SHR, MD_ROW_ROR: bad = amt_zero;
            MD_QUAD, MD_WAVE_SHL, MD_WAVE_SHR, MD_WAVE_ROL, MD_WAVE_ROR,
            MD_ROW_MIR, MD_HALF_MIR, MD_BC15, MD_BC31: bad = 1'b0;
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/lperm_lane_route.sv
module lperm_lane_route
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int ROW   = 16,
    parameter int QUAD  = 4,
    parameter int LANE  = 0
) (
    input  logic [3:0]                      mode,
    input  logic [QUAD*$clog2(QUAD)-1:0]    ctrl,
    input  logic                            bound_zero,
    output logic [$clog2(LANES)-1:0]        src_idx,
    output pick_e                           pick
);
    localparam int IDX_W = $clog2(LANES);
    localparam int QF_W  = $clog2(QUAD);
    localparam int AMT_W = $clog2(ROW);
    localparam int HALF  = ROW / 2;
    localparam int POS   = LANE % ROW;
    localparam int RBASE = LANE - POS;
    localparam int RIDX  = LANE / ROW;
    localparam int HPOS  = LANE % HALF;
    localparam int HBASE = LANE - HPOS;
    localparam int QPOS  = LANE % QUAD;
    localparam int QBASE = LANE - QPOS;

    logic [QF_W-1:0] qfield;
    int              amt;
    int              tgt;
    pick_e           oob_pick;

    assign qfield   = QF_W'(ctrl >> (QF_W * QPOS));
    assign amt      = int'(ctrl[AMT_W-1:0]);
    assign oob_pick = bound_zero ? PK_ZERO : PK_OLD;

    always_comb begin
        tgt  = LANE;
        pick = PK_SRC;
        unique case (mode)
            MD_QUAD:     tgt = QBASE + int'(qfield);
            MD_WAVE_SHL: begin
                if (LANE + 1 < LANES) tgt = LANE + 1;
                else                  pick = oob_pick;
            end
            MD_WAVE_SHR: begin
                if (LANE > 0) tgt = LANE - 1;
                else          pick = oob_pick;
            end
            MD_WAVE_ROL: tgt = (LANE + 1) % LANES;
            MD_WAVE_ROR: tgt = (LANE + LANES - 1) % LANES;
            MD_ROW_SHL: begin
                if (amt != 0) begin
                    if (POS + amt < ROW) tgt = RBASE + POS + amt;
                    else                 pick = oob_pick;
                end
            end
            MD_ROW_SHR: begin
                if (amt != 0) begin
                    if (POS >= amt) tgt = RBASE + POS - amt;
                    else            pick = oob_pick;
                end
            end
            MD_ROW_ROR:  tgt = RBASE + ((POS - amt + ROW) % ROW);
            MD_ROW_MIR:  tgt = RBASE + ROW - 1 - POS;
            MD_HALF_MIR: tgt = HBASE + HALF - 1 - HPOS;
            MD_BC15: begin
                if (RIDX == 0) pick = PK_OLD;
                else           tgt = RBASE - 1;
            end
            MD_BC31: begin
                if (RIDX < 2) pick = PK_OLD;
                else          tgt = 2 * ROW - 1;
            end
            default: tgt = LANE;
        endcase
    end

    assign src_idx = IDX_W'(tgt);

endmodule

// File: rtl/lperm_gather.sv
module lperm_gather
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int W     = 32,
    parameter int IDX_W = 6
) (
    input  logic [LANES*W-1:0]     src_data,
    input  logic [LANES*W-1:0]     old_data,
    input  logic [LANES*IDX_W-1:0] idx_flat,
    input  logic [2*LANES-1:0]     pick_flat,
    output logic [LANES*W-1:0]     res_data
);
    logic [W-1:0] src_w [LANES];

    for (genvar s = 0; s < LANES; s++) begin : g_split
        assign src_w[s] = src_data[s*W +: W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] ix;
        pick_e            pk;
        logic [W-1:0]     fetched;
        logic [W-1:0]     lane_out;

        assign ix      = idx_flat[l*IDX_W +: IDX_W];
        assign pk      = pick_e'(pick_flat[2*l +: 2]);
        assign fetched = src_w[ix];

        always_comb begin
            unique case (pk)
                PK_SRC:  lane_out = fetched;
                PK_ZERO: lane_out = '0;
                PK_OLD:  lane_out = old_data[l*W +: W];
                default: lane_out = fetched;
            endcase
        end

        assign res_data[l*W +: W] = lane_out;
    end

endmodule

// File: rtl/lperm_top.sv
module lperm_top
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int W     = 32,
    parameter int ROW   = 16,
    parameter int QUAD  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [3:0]                   mode,
    input  logic [QUAD*$clog2(QUAD)-1:0] ctrl,
    input  logic                         bound_zero,
    input  logic [LANES*W-1:0]           src_data,
    input  logic [LANES*W-1:0]           old_data,
    output logic                         out_valid,
    output logic [LANES*W-1:0]           out_data,
    output logic                         out_err
);
    localparam int IDX_W  = $clog2(LANES);
    localparam int AMT_W  = $clog2(ROW);
    localparam int DATA_W = LANES * W;

    logic [LANES*IDX_W-1:0] idx_flat;
    logic [2*LANES-1:0]     pick_flat;
    logic [DATA_W-1:0]      next_data;
    logic                   next_err;

    for (genvar l = 0; l < LANES; l++) begin : g_route
        pick_e pk;
        lperm_lane_route #(
            .LANES (LANES),
            .ROW   (ROW),
            .QUAD  (QUAD),
            .LANE  (l)
        ) u_route (
            .mode       (mode),
            .ctrl       (ctrl),
            .bound_zero (bound_zero),
            .src_idx    (idx_flat[l*IDX_W +: IDX_W]),
            .pick       (pk)
        );
        assign pick_flat[2*l +: 2] = pk;
    end

    lperm_gather #(
        .LANES (LANES),
        .W     (W),
        .IDX_W (IDX_W)
    ) u_gather (
        .src_data  (src_data),
        .old_data  (old_data),
        .idx_flat  (idx_flat),
        .pick_flat (pick_flat),
        .res_data  (next_data)
    );

    assign next_err = mode_illegal(mode, ctrl[AMT_W-1:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
                out_err  <= next_err;
            end
        end
    end

endmodule

// File: rtl/lperm_chk.sv
module lperm_chk #(
    parameter int LANES = 64,
    parameter int W     = 32,
    parameter int ROW   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [3:0]           mode,
    input logic [$clog2(ROW)-1:0] row_amt,
    input logic [W-1:0]         src_first,
    input logic [W-1:0]         src_row_end,
    input logic [W-1:0]         old_first,
    input logic                 out_valid,
    input logic [LANES*W-1:0]   out_data,
    input logic                 out_err
);
    logic row_mode;
    assign row_mode = (mode == 4'd5) || (mode == 4'd6) || (mode == 4'd7);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_err)));
    p_rol_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd3) |=> out_data[(LANES-1)*W +: W] == $past(src_first));
    p_mirror_lane0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd8) |=> out_data[W-1:0] == $past(src_row_end));
    p_bc31_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd11) |=> out_data[W-1:0] == $past(old_first));
    p_err_zero_amt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((row_mode && row_amt == '0) || mode > 4'd11)) |=> out_err);
    p_err_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode <= 4'd11 && !(row_mode && row_amt == '0)) |=> !out_err);

endmodule

bind lperm_top lperm_chk #(
    .LANES (LANES),
    .W     (W),
    .ROW   (ROW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .mode        (mode),
    .row_amt     (ctrl[AMT_W-1:0]),
    .src_first   (src_data[W-1:0]),
    .src_row_end (src_data[(ROW-1)*W +: W]),
    .old_first   (old_data[W-1:0]),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_err     (out_err)
);

// File: tb/tb_lperm_top.sv
module tb_lperm_top;
    localparam int LANES = 64;
    localparam int W     = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [3:0]         mode = '0;
    logic [7:0]         ctrl = '0;
    logic               bound_zero = 1'b0;
    logic [LANES*W-1:0] src_data = '0;
    logic [LANES*W-1:0] old_data = '0;
    logic               out_valid;
    logic [LANES*W-1:0] out_data;
    logic               out_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lperm_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ctrl(ctrl),
        .bound_zero(bound_zero), .src_data(src_data), .old_data(old_data),
        .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [W-1:0] src_w(int l);
        return src_data[l*W +: W];
    endfunction
    function automatic logic [W-1:0] old_w(int l);
        return old_data[l*W +: W];
    endfunction

    // Expected word per lane, written from the requirements.
    function automatic logic [W-1:0] ref_lane(int l, logic [3:0] m, logic [7:0] c, logic bz);
        int p = l % 16, b = l - (l % 16), r = l / 16, n = int'(c[3:0]);
        int s = l;
        bit none = 0, keep = 0;
        case (m)
            4'd0: s = (l / 4) * 4 + int'((c >> (2 * (l % 4))) & 8'd3);
            4'd1: if (l == 63) none = 1; else s = l + 1;
            4'd2: if (l == 0) none = 1; else s = l - 1;
            4'd3: s = (l == 63) ? 0 : l + 1;
            4'd4: s = (l == 0) ? 63 : l - 1;
            4'd5: if (n != 0) begin if (p + n > 15) none = 1; else s = b + p + n; end
            4'd6: if (n != 0) begin if (p < n) none = 1; else s = b + p - n; end
            4'd7: s = b + ((p - n + 16) % 16);
            4'd8: s = b + 15 - p;
            4'd9: s = (l - l % 8) + 7 - (l % 8);
            4'd10: if (r == 0) keep = 1; else s = 16 * r - 1;
            4'd11: if (r < 2) keep = 1; else s = 31;
            default: s = l;
        endcase
        if (keep) return old_w(l);
        if (none) return bz ? '0 : old_w(l);
        return src_w(s);
    endfunction

    task automatic load_pattern(int seed);
        for (int l = 0; l < LANES; l++) begin
            src_data[l*W +: W] = 32'h1000_0000 + (seed << 16) + l;
            old_data[l*W +: W] = 32'hF000_0000 + (seed << 16) + l;
        end
    endtask

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One strobe; results are read at the falling edge after the capturing edge.
    task automatic run(string req, logic [3:0] m, logic [7:0] c, logic bz, int seed);
        logic [LANES*W-1:0] exp_v;
        logic               exp_err;
        int                 bad_lane;
        @(negedge clk);
        load_pattern(seed);
        mode = m; ctrl = c; bound_zero = bz; in_valid = 1'b1;
        for (int l = 0; l < LANES; l++) exp_v[l*W +: W] = ref_lane(l, m, c, bz);
        exp_err = (m > 4'd11) || ((m >= 4'd5 && m <= 4'd7) && c[3:0] == 4'd0);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_data !== exp_v) begin
            errors++;
            bad_lane = 0;
            for (int l = LANES - 1; l >= 0; l--)
                if (out_data[l*W +: W] !== exp_v[l*W +: W]) bad_lane = l;
            $display("FAIL %s mode=%0d ctrl=%h bz=%0b lane %0d: actual=%h expected=%h",
                     req, m, c, bz, bad_lane, out_data[bad_lane*W +: W], exp_v[bad_lane*W +: W]);
        end
        check_bit("R2", "out_valid", out_valid, 1'b1);
        check_bit(exp_err ? "R12" : "R13", "out_err", out_err, exp_err);
    endtask

    task automatic t_reset();
        checks++;
        if (out_data !== '0) begin
            errors++;
            $display("FAIL R1 out_data: actual=%h expected=0", out_data[W-1:0]);
        end
        check_bit("R1", "out_valid", out_valid, 1'b0);
        check_bit("R1", "out_err", out_err, 1'b0);
    endtask

    task automatic t_quad();
        run("R3", 4'd0, 8'b00_01_10_11, 1'b0, 1);
        run("R3", 4'd0, 8'b10_10_00_01, 1'b1, 2);
    endtask

    task automatic t_wave();
        run("R4 R8", 4'd1, 8'h00, 1'b0, 3);
        run("R4 R8", 4'd1, 8'h00, 1'b1, 4);
        run("R4 R8", 4'd2, 8'h00, 1'b0, 5);
        run("R4 R8", 4'd2, 8'h00, 1'b1, 6);
        run("R5", 4'd3, 8'h00, 1'b0, 7);
        run("R5", 4'd4, 8'h00, 1'b1, 8);
    endtask

    task automatic t_row_shift();
        run("R6 R8", 4'd5, 8'h01, 1'b0, 9);
        run("R6 R8", 4'd5, 8'h0F, 1'b1, 10);
        run("R6 R8", 4'd6, 8'h05, 1'b0, 11);
        run("R6 R8", 4'd6, 8'hF5, 1'b1, 12);
    endtask

    task automatic t_row_rot();
        run("R7", 4'd7, 8'h01, 1'b1, 13);
        run("R7", 4'd7, 8'h0F, 1'b0, 14);
        run("R7", 4'd7, 8'h06, 1'b0, 15);
    endtask

    task automatic t_mirror();
        run("R9", 4'd8, 8'h00, 1'b0, 16);
        run("R9", 4'd9, 8'h00, 1'b1, 17);
    endtask

    task automatic t_bcast();
        run("R10", 4'd10, 8'h00, 1'b1, 18);
        run("R10", 4'd10, 8'h00, 1'b0, 19);
        run("R11", 4'd11, 8'h00, 1'b1, 20);
    endtask

    task automatic t_illegal();
        run("R12", 4'd5, 8'h00, 1'b1, 21);
        run("R12", 4'd6, 8'hF0, 1'b1, 22);
        run("R12", 4'd7, 8'h00, 1'b0, 23);
        run("R12", 4'd13, 8'h03, 1'b1, 24);
    endtask

    task automatic t_hold();
        logic [LANES*W-1:0] kept;
        logic               kept_err;
        run("R2", 4'd5, 8'h00, 1'b0, 25);
        kept = out_data;
        kept_err = out_err;
        @(negedge clk);
        load_pattern(26);
        mode = 4'd1; ctrl = 8'h02; bound_zero = 1'b1;
        @(negedge clk);
        checks++;
        if (out_data !== kept) begin
            errors++;
            $display("FAIL R2 hold: actual=%h expected=%h", out_data[W-1:0], kept[W-1:0]);
        end
        check_bit("R2", "out_err hold", out_err, kept_err);
        check_bit("R2", "out_valid low", out_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quad();
        t_wave();
        t_row_shift();
        t_row_rot();
        t_mirror();
        t_bcast();
        t_illegal();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule